// File: doc/BRIEF.md
# USART processor-side register interface

This block is the part of a programmable serial controller that faces the processor bus. It turns chip-select, read and write strobes and a control/data select line into single accesses. Each write goes to one of four places: the transmit holding register, the mode register, one of two sync-character registers or the command register. A read returns either the received character or a status byte. The serial shifters, baud timing and receive framing sit outside the block. They talk to it only through status and event inputs, the held transmit character and the enable and handshake outputs.

The meaning of a control write depends on how far a post-reset sequence has advanced. The first control write after reset configures the mode. If that mode selects synchronous clocking, the next one or two control writes are stored as sync characters. Every control write after that is a command. A command can pulse a clear of the sticky error flags. It can also restart the whole sequence through an internal reset that does not use the reset pin.

Top module: `usart_cpu_if`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the block clears everything. The mode, sync and command registers go to zero, the holding register is empty, RxRDY and all error flags are cleared, and the sequencer waits for a mode write.
- R2: The first control write (`cd`=1) after reset is stored unchanged in the mode register (`mode_o`).
- R3: If the mode's clock-factor field (bits 1:0) is 00, the following control writes are stored as sync characters. With mode bit 7 = 1 there is one sync character (`sync1_o`). With mode bit 7 = 0 there are two (`sync1_o`, then `sync2_o`).
- R4: Once the mode write and any sync writes are done, each control write is a command. Command bit 0 sets transmit enable, bit 1 DTR, bit 2 receive enable, bit 3 break and bit 5 RTS. These outputs hold until the next command.
- R5: An access is taken once for each period in which `cs_n` and the strobe are both low, on its first clock. Strobes while `cs_n` is high are ignored.
- R6: A data write (`cd`=0) loads `thr_o` and sets `thr_full_o`. A `tx_load_i` pulse empties the register. `tx_rdy_o` = transmit enable AND NOT full.
- R7: A `rx_valid_i` pulse captures `rx_data_i` and sets RxRDY. A data read returns the captured character and clears RxRDY.
- R8: A status read (`cd`=1) returns these bits: 0 = holding register empty, 1 = RxRDY, 2 = empty AND `tx_idle_i`, 3 = parity error, 4 = overrun, 5 = framing error, 6 = 0, 7 = `dsr_i`.
- R9: `par_err_i` and `frm_err_i` pulses set sticky flags. A received character that arrives while RxRDY is set and is not being read sets the sticky overrun flag.
- R10: Command bit 4 clears all three sticky error flags. It does not change the other command outputs.
- R11: Command bit 6 is an internal reset. It has the full effect of R1 and ignores the other bits of that command.
- R12: `dout` is zero whenever no read access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cd | input | 1 | 1 = control/status access, 0 = data access |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| rx_valid_i | input | 1 | Receiver has a complete character (one-cycle pulse) |
| rx_data_i | input | 8 | Received character |
| par_err_i | input | 1 | Parity error event (pulse) |
| frm_err_i | input | 1 | Framing error event (pulse) |
| tx_load_i | input | 1 | Transmit shifter took the held character (pulse) |
| tx_idle_i | input | 1 | Transmit shifter is idle |
| dsr_i | input | 1 | Data-set-ready level, reported in status |
| mode_o | output | 8 | Mode register |
| sync1_o | output | 8 | First sync character |
| sync2_o | output | 8 | Second sync character |
| thr_o | output | 8 | Transmit holding register |
| thr_full_o | output | 1 | Holding register holds an unsent character |
| tx_rdy_o | output | 1 | Ready for a new transmit character |
| rx_rdy_o | output | 1 | Received character waiting |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| dtr_o | output | 1 | Data-terminal-ready request |
| rts_o | output | 1 | Request-to-send |
| brk_o | output | 1 | Break request |

## Verification
A write is captured at the first rising edge that sees the strobe low, so its effect on the register outputs appears one edge after the bus is driven. The bench drives on falling edges and checks registers at the falling edge after release. Read data is combinational, so it is sampled 1 time unit after the strobe is driven and before any edge. The RxRDY clear and the error-flag updates land on the edge inside the access or pulse, and are read back at the next falling edge through the pins or a status read. Random mode, sync, command and data bytes from a fixed seed drive a bench-side model of the sequence. Directed cases cover a held strobe, a deselected strobe, overrun, error clear and both reset paths.

// File: rtl/usart_cpu_pkg.sv
// Package: types and bit positions shared by the USART processor interface.
// Assumes an 8-bit processor bus and an 8-bit mode register.
package usart_cpu_pkg;

    localparam int BYTE_W  = 8;
    localparam int NSYNC   = 2;

    // Sequencer phase: which register the next control write targets
    typedef enum logic [1:0] {
        PH_MODE  = 2'd0,
        PH_SYNC1 = 2'd1,
        PH_SYNC2 = 2'd2,
        PH_CMD   = 2'd3
    } seq_phase_t;

    // Mode register layout, MSB first
    typedef struct packed {
        logic [1:0] frame_ctl;   // stop bits, or in sync mode bit 1 = single sync
        logic       par_even;
        logic       par_en;
        logic [1:0] char_len;    // 00 = 5 bits .. 11 = 8 bits
        logic [1:0] clk_factor;  // 00 = synchronous
    } mode_t;

    localparam logic [1:0] CLK_SYNC = 2'b00;

    // Held command outputs
    typedef struct packed {
        logic rts;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_flags_t;

    // Command byte bit positions
    localparam int CMD_TXEN   = 0;
    localparam int CMD_DTR    = 1;
    localparam int CMD_RXEN   = 2;
    localparam int CMD_BRK    = 3;
    localparam int CMD_ERRCLR = 4;
    localparam int CMD_RTS    = 5;
    localparam int CMD_SRST   = 6;

    // Status byte bit positions
    localparam int ST_TXRDY = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_TXE   = 2;
    localparam int ST_PE    = 3;
    localparam int ST_OE    = 4;
    localparam int ST_FE    = 5;
    localparam int ST_DSR   = 7;

endpackage

// File: rtl/usart_bus_decode.sv
// Bus decode: turns the level strobes into one-cycle access pulses.
// Assumes the strobes are synchronous to clk. An access fires on the first
// clock on which chip select and its strobe are both low.
module usart_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic cd,
    output logic wr_ctl_o,
    output logic wr_data_o,
    output logic rd_data_o,
    output logic rd_act_o
);

    logic wr_act;
    logic wr_seen_q;
    logic rd_seen_q;
    logic wr_pulse;

    assign wr_act   = !cs_n && !wr_n;
    assign rd_act_o = !cs_n && !rd_n;

    // Remember the strobe levels of the previous cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
            rd_seen_q <= 1'b0;
        end else begin
            wr_seen_q <= wr_act;
            rd_seen_q <= rd_act_o;
        end
    end

    // Leading-edge pulses, split by control/data select
    always_comb begin
        wr_pulse  = wr_act && !wr_seen_q;
        wr_ctl_o  = wr_pulse && cd;
        wr_data_o = wr_pulse && !cd;
        rd_data_o = rd_act_o && !rd_seen_q && !cd;
    end

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse) else $error("write pulse repeated"); // R5

endmodule

// File: rtl/usart_ctl_seq.sv
// Control-word sequencer. It steers control writes to the mode register,
// the sync registers or the command register, depending on the phase after
// reset. It raises the error-clear and internal-reset pulses from command
// bits. Assumes wr_ctl_i is a one-cycle pulse from the bus decode.
module usart_ctl_seq
    import usart_cpu_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl_i,
    input  logic [DW-1:0] din_i,
    output mode_t         mode_o,
    output logic [DW-1:0] sync1_o,
    output logic [DW-1:0] sync2_o,
    output cmd_flags_t    cmd_o,
    output logic          err_clr_o,
    output logic          soft_rst_o
);

    localparam int MODE_W = $bits(mode_t);

    seq_phase_t    phase_q, phase_d;
    mode_t         mode_q;
    mode_t         din_mode;
    cmd_flags_t    cmd_q;
    logic [DW-1:0] sync_q [NSYNC];

    assign din_mode = mode_t'(din_i[MODE_W-1:0]);

    // Command pulses decoded from a write in the command phase
    always_comb begin
        soft_rst_o = wr_ctl_i && (phase_q == PH_CMD) && din_i[CMD_SRST];
        err_clr_o  = wr_ctl_i && (phase_q == PH_CMD) && din_i[CMD_ERRCLR]
                     && !din_i[CMD_SRST];
    end

    // Next phase of the control-word sequence
    always_comb begin
        phase_d = phase_q;
        if (wr_ctl_i) begin
            case (phase_q)
                PH_MODE:  phase_d = (din_mode.clk_factor == CLK_SYNC) ? PH_SYNC1 : PH_CMD;
                PH_SYNC1: phase_d = mode_q.frame_ctl[1] ? PH_CMD : PH_SYNC2;
                PH_SYNC2: phase_d = PH_CMD;
                PH_CMD:   phase_d = din_i[CMD_SRST] ? PH_MODE : PH_CMD;
                default:  phase_d = PH_MODE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_MODE;
        else        phase_q <= phase_d;
    end

    // Mode register, written only in the mode phase
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o)                     mode_q <= '0;
        else if (wr_ctl_i && (phase_q == PH_MODE))    mode_q <= din_mode;
    end

    // Sync character registers, one per sync phase
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        localparam seq_phase_t TGT = (g == 0) ? PH_SYNC1 : PH_SYNC2;
        // Capture a sync character when its phase is current
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst_o)              sync_q[g] <= '0;
            else if (wr_ctl_i && (phase_q == TGT)) sync_q[g] <= din_i;
        end
    end

    // Command register holding the level outputs
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o) begin
            cmd_q <= '0;
        end else if (wr_ctl_i && (phase_q == PH_CMD)) begin
            cmd_q.tx_en <= din_i[CMD_TXEN];
            cmd_q.dtr   <= din_i[CMD_DTR];
            cmd_q.rx_en <= din_i[CMD_RXEN];
            cmd_q.brk   <= din_i[CMD_BRK];
            cmd_q.rts   <= din_i[CMD_RTS];
        end
    end

    assign mode_o  = mode_q;
    assign sync1_o = sync_q[0];
    assign sync2_o = sync_q[1];
    assign cmd_o   = cmd_q;

    AST_MODE_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(phase_q) == PH_MODE || $past(soft_rst_o)))
        else $error("mode changed outside mode phase"); // R2
    AST_SYNC2_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[1] != $past(sync_q[1])) |-> ($past(phase_q) == PH_SYNC2 || $past(soft_rst_o)))
        else $error("second sync changed outside its phase"); // R3
    AST_CMD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != $past(cmd_q)) |-> ($past(phase_q) == PH_CMD))
        else $error("command changed before sequence end"); // R4
    AST_SRST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (phase_q == PH_MODE && cmd_q == '0))
        else $error("internal reset did not restart"); // R11

endmodule

// File: rtl/usart_rx_status.sv
// Receive buffer and sticky error flags. It captures each received character,
// keeps RxRDY until a data read, and holds the parity, overrun and framing
// flags until an error clear or a reset. Assumes event inputs are one-cycle
// pulses.
module usart_rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all_i,
    input  logic          err_clr_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rd_data_i,
    input  logic          par_err_i,
    input  logic          frm_err_i,
    output logic [DW-1:0] rx_buf_o,
    output logic          rx_rdy_o,
    output logic          pe_o,
    output logic          oe_o,
    output logic          fe_o
);

    logic          lost_char;
    logic [DW-1:0] buf_q;
    logic          rdy_q, pe_q, oe_q, fe_q;

    assign lost_char = rx_valid_i && rdy_q && !rd_data_i;

    // Receive character buffer
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) buf_q <= '0;
        else if (rx_valid_i)     buf_q <= rx_data_i;
    end

    // RxRDY: set by a new character, cleared by a data read
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) rdy_q <= 1'b0;
        else if (rx_valid_i)     rdy_q <= 1'b1;
        else if (rd_data_i)      rdy_q <= 1'b0;
    end

    // Sticky error flags; a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) begin
            pe_q <= 1'b0;
            oe_q <= 1'b0;
            fe_q <= 1'b0;
        end else begin
            pe_q <= par_err_i || (pe_q && !err_clr_i);
            oe_q <= lost_char || (oe_q && !err_clr_i);
            fe_q <= frm_err_i || (fe_q && !err_clr_i);
        end
    end

    assign rx_buf_o = buf_q;
    assign rx_rdy_o = rdy_q;
    assign pe_o     = pe_q;
    assign oe_o     = oe_q;
    assign fe_o     = fe_q;

    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rdy_q && !rd_data_i && !clr_all_i) |=> oe_q)
        else $error("lost character without overrun"); // R9
    AST_RXRDY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !rx_valid_i) |=> !rdy_q)
        else $error("RxRDY held after data read"); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !par_err_i && !frm_err_i && !rx_valid_i) |=> (!pe_q && !oe_q && !fe_q))
        else $error("error flags survived clear"); // R10

endmodule

// File: rtl/usart_tx_hold.sv
// Transmit holding register. A data write loads it and marks it full, and
// the shifter's load pulse empties it. A write in the same cycle as a load
// keeps it full with the new character.
module usart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all_i,
    input  logic          wr_data_i,
    input  logic [DW-1:0] din_i,
    input  logic          tx_load_i,
    output logic [DW-1:0] thr_o,
    output logic          full_o
);

    logic [DW-1:0] thr_q;
    logic          full_q;

    // Character storage
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) thr_q <= '0;
        else if (wr_data_i)      thr_q <= din_i;
    end

    // Full flag: write sets, shifter load clears
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all_i) full_q <= 1'b0;
        else if (wr_data_i)      full_q <= 1'b1;
        else if (tx_load_i)      full_q <= 1'b0;
    end

    assign thr_o  = thr_q;
    assign full_o = full_q;

    AST_THR_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_i |=> full_q)
        else $error("holding register not full after write"); // R6

endmodule

// File: rtl/usart_cpu_if.sv
// Top: processor-side interface of the USART. It joins the bus decode, the
// control sequencer, the receive/status store and the transmit holding
// register, and forms the read multiplexer and the status byte. Assumes all
// inputs are synchronous to clk.
module usart_cpu_if
    import usart_cpu_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          par_err_i,
    input  logic          frm_err_i,
    input  logic          tx_load_i,
    input  logic          tx_idle_i,
    input  logic          dsr_i,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] sync1_o,
    output logic [DW-1:0] sync2_o,
    output logic [DW-1:0] thr_o,
    output logic          thr_full_o,
    output logic          tx_rdy_o,
    output logic          rx_rdy_o,
    output logic          tx_en_o,
    output logic          rx_en_o,
    output logic          dtr_o,
    output logic          rts_o,
    output logic          brk_o
);

    logic          wr_ctl, wr_data, rd_data, rd_act;
    logic          err_clr, soft_rst;
    mode_t         mode_w;
    cmd_flags_t    cmd_w;
    logic [DW-1:0] rx_buf;
    logic          pe, oe, fe;
    logic [DW-1:0] status;

    usart_bus_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .cd        (cd),
        .wr_ctl_o  (wr_ctl),
        .wr_data_o (wr_data),
        .rd_data_o (rd_data),
        .rd_act_o  (rd_act)
    );

    usart_ctl_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl_i   (wr_ctl),
        .din_i      (din),
        .mode_o     (mode_w),
        .sync1_o    (sync1_o),
        .sync2_o    (sync2_o),
        .cmd_o      (cmd_w),
        .err_clr_o  (err_clr),
        .soft_rst_o (soft_rst)
    );

    usart_rx_status #(.DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (soft_rst),
        .err_clr_i  (err_clr),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .rd_data_i  (rd_data),
        .par_err_i  (par_err_i),
        .frm_err_i  (frm_err_i),
        .rx_buf_o   (rx_buf),
        .rx_rdy_o   (rx_rdy_o),
        .pe_o       (pe),
        .oe_o       (oe),
        .fe_o       (fe)
    );

    usart_tx_hold #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all_i (soft_rst),
        .wr_data_i (wr_data),
        .din_i     (din),
        .tx_load_i (tx_load_i),
        .thr_o     (thr_o),
        .full_o    (thr_full_o)
    );

    // Status byte assembly
    always_comb begin
        status           = '0;
        status[ST_TXRDY] = !thr_full_o;
        status[ST_RXRDY] = rx_rdy_o;
        status[ST_TXE]   = !thr_full_o && tx_idle_i;
        status[ST_PE]    = pe;
        status[ST_OE]    = oe;
        status[ST_FE]    = fe;
        status[ST_DSR]   = dsr_i;
    end

    // Read multiplexer, zero when no read is active
    always_comb begin
        if (!rd_act) dout = '0;
        else if (cd) dout = status;
        else         dout = rx_buf;
    end

    assign mode_o   = mode_w;
    assign tx_en_o  = cmd_w.tx_en;
    assign rx_en_o  = cmd_w.rx_en;
    assign dtr_o    = cmd_w.dtr;
    assign rts_o    = cmd_w.rts;
    assign brk_o    = cmd_w.brk;
    assign tx_rdy_o = cmd_w.tx_en && !thr_full_o;

endmodule

// File: tb/test_usart_cpu_if.sv
// Bench for usart_cpu_if: random sequences from a fixed seed, checked
// against a bench-side model, plus directed corner cases.
module test_usart_cpu_if;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = '0;
    logic       par_err_i = 1'b0, frm_err_i = 1'b0, tx_load_i = 1'b0;
    logic       tx_idle_i = 1'b1, dsr_i = 1'b0;
    logic [7:0] mode_o, sync1_o, sync2_o, thr_o;
    logic       thr_full_o, tx_rdy_o, rx_rdy_o, tx_en_o, rx_en_o, dtr_o, rts_o, brk_o;

    int errors = 0;
    int checks = 0;

    // Model state
    int         m_phase;
    logic [7:0] m_mode, m_sync1, m_sync2, m_thr, m_rxbuf;
    logic [4:0] m_cmd;    // {rts, brk, rx_en, dtr, tx_en}
    logic       m_full, m_rxrdy, m_pe, m_oe, m_fe;

    always #(CLK_PERIOD/2) clk = ~clk;

    usart_cpu_if i_usart_cpu_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .cd(cd),
        .din(din), .dout(dout), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .par_err_i(par_err_i), .frm_err_i(frm_err_i), .tx_load_i(tx_load_i),
        .tx_idle_i(tx_idle_i), .dsr_i(dsr_i), .mode_o(mode_o), .sync1_o(sync1_o),
        .sync2_o(sync2_o), .thr_o(thr_o), .thr_full_o(thr_full_o), .tx_rdy_o(tx_rdy_o),
        .rx_rdy_o(rx_rdy_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .dtr_o(dtr_o),
        .rts_o(rts_o), .brk_o(brk_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_phase = 0; m_mode = 0; m_sync1 = 0; m_sync2 = 0; m_cmd = 0;
        m_thr = 0; m_full = 0; m_rxbuf = 0; m_rxrdy = 0;
        m_pe = 0; m_oe = 0; m_fe = 0;
    endtask

    function automatic logic [7:0] exp_status();
        return {dsr_i, 1'b0, m_fe, m_oe, m_pe, !m_full && tx_idle_i, m_rxrdy, !m_full};
    endfunction

    function automatic logic [4:0] cmd_pins();
        return {rts_o, brk_o, rx_en_o, dtr_o, tx_en_o};
    endfunction

    // Model of one control write
    task automatic model_ctl(input logic [7:0] v);
        case (m_phase)
            0: begin m_mode = v; m_phase = (v[1:0] == 2'b00) ? 1 : 3; end
            1: begin m_sync1 = v; m_phase = m_mode[7] ? 3 : 2; end
            2: begin m_sync2 = v; m_phase = 3; end
            default: begin
                if (v[6]) model_clear();
                else begin
                    m_cmd = {v[5], v[3], v[2], v[1], v[0]};
                    if (v[4]) begin m_pe = 0; m_oe = 0; m_fe = 0; end
                end
            end
        endcase
    endtask

    // Compare every register output with the model
    task automatic chk_regs(input string req);
        chk({req, " mode"}, mode_o, m_mode);
        chk({req, " sync1"}, sync1_o, m_sync1);
        chk({req, " sync2"}, sync2_o, m_sync2);
        chk({req, " cmd"}, {3'b0, cmd_pins()}, {3'b0, m_cmd});
        chk({req, " thr"}, thr_o, m_thr);
        chk({req, " full/rdy"}, {5'b0, thr_full_o, tx_rdy_o, rx_rdy_o},
            {5'b0, m_full, m_cmd[0] && !m_full, m_rxrdy});
    endtask

    // Write with the strobe held for hold cycles
    task automatic bus_write(input logic c, input logic [7:0] v, input int hold);
        @(negedge clk);
        cs_n = 0; wr_n = 0; cd = c; din = v;
        repeat (hold) @(negedge clk);
        cs_n = 1; wr_n = 1;
        if (c) model_ctl(v);
        else begin m_thr = v; m_full = 1; end
    endtask

    task automatic bus_read(input logic c, output logic [7:0] v);
        @(negedge clk);
        cs_n = 0; rd_n = 0; cd = c;
        #1 v = dout;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        if (!c) m_rxrdy = 0;
    endtask

    task automatic rx_char(input logic [7:0] v);
        @(negedge clk);
        rx_valid_i = 1; rx_data_i = v;
        @(negedge clk);
        rx_valid_i = 0;
        if (m_rxrdy) m_oe = 1;
        m_rxbuf = v; m_rxrdy = 1;
    endtask

    task automatic pulse_err(input logic p, input logic f);
        @(negedge clk);
        par_err_i = p; frm_err_i = f;
        @(negedge clk);
        par_err_i = 0; frm_err_i = 0;
        if (p) m_pe = 1;
        if (f) m_fe = 1;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_load_i = 1;
        @(negedge clk);
        tx_load_i = 0;
        m_full = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // Main stimulus
    initial begin
        logic [7:0] rv;
        void'($urandom(32'h5A17));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state and R12 idle output
        chk_regs("R1 reset");
        chk("R12 idle dout", dout, 8'h00);
        bus_read(1'b1, rv);
        chk("R8 status after reset", rv, exp_status());

        // R5 directed: strobe while deselected is ignored
        @(negedge clk); cd = 1; din = 8'h4E; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk);
        chk("R5 deselected write ignored", mode_o, 8'h00);

        // R3 directed: two syncs, first write held for 3 cycles
        bus_write(1'b1, 8'h0C, 1);          // sync mode, bit7=0 -> two syncs
        @(negedge clk);
        chk("R2 mode stored", mode_o, 8'h0C);
        bus_write(1'b1, 8'hA5, 3);
        @(negedge clk);
        chk("R5 held strobe one write sync1", sync1_o, 8'hA5);
        chk("R5 held strobe sync2 untouched", sync2_o, 8'h00);
        bus_write(1'b1, 8'h3C, 1);
        bus_write(1'b1, 8'h27, 1);          // command tx_en dtr rx_en rts
        @(negedge clk);
        chk_regs("R3 R4 two-sync sequence");

        // R9 overrun directed, R10 clear
        rx_char(8'h11);
        rx_char(8'h22);
        bus_read(1'b1, rv);
        chk("R9 overrun status", rv, exp_status());
        bus_read(1'b0, rv);
        chk("R7 data read", rv, 8'h22);
        @(negedge clk);
        chk("R7 rxrdy cleared", {7'b0, rx_rdy_o}, 8'h00);
        pulse_err(1'b1, 1'b1);
        bus_read(1'b1, rv);
        chk("R9 parity framing sticky", rv, exp_status());
        bus_write(1'b1, 8'h17, 1);          // error clear plus enables
        bus_read(1'b1, rv);
        chk("R10 errors cleared", rv, exp_status());
        chk_regs("R10 command outputs");

        // R1 second reset restarts the sequence
        do_reset();
        @(negedge clk);
        chk_regs("R1 second reset");
        bus_write(1'b1, 8'h4E, 1);          // async mode
        bus_write(1'b1, 8'h21, 1);          // command
        @(negedge clk);
        chk_regs("R2 R4 after reset");

        // Random sequences
        for (int it = 0; it < 24; it++) begin
            logic [7:0] md;
            tx_idle_i = $urandom_range(0, 1);
            dsr_i     = $urandom_range(0, 1);
            if (m_phase != 0) begin
                bus_write(1'b1, 8'h40 | 8'($urandom_range(0, 255)), 1);  // R11 soft reset
                @(negedge clk);
                chk_regs("R11 internal reset");
            end
            md = 8'($urandom_range(0, 255));
            if (it % 2 == 0) md[1:0] = 2'b00;
            bus_write(1'b1, md, 1);
            @(negedge clk);
            chk("R2 random mode", mode_o, m_mode);
            while (m_phase == 1 || m_phase == 2) bus_write(1'b1, 8'($urandom_range(0, 255)), 1);
            @(negedge clk);
            chk_regs("R3 random sync");
            for (int k = 0; k < 3; k++) begin
                bus_write(1'b1, 8'($urandom_range(0, 255)) & 8'hBF, 1);
                @(negedge clk);
                chk_regs("R4 random command");
            end
            bus_write(1'b0, 8'($urandom_range(0, 255)), 1);
            @(negedge clk);
            chk_regs("R6 data write");
            if ($urandom_range(0, 1) == 1) begin
                tx_take();
                @(negedge clk);
                chk_regs("R6 shifter load");
            end
            for (int k = 0; k < int'($urandom_range(1, 2)); k++) rx_char(8'($urandom_range(0, 255)));
            if ($urandom_range(0, 1) == 1) pulse_err($urandom_range(0, 1), $urandom_range(0, 1));
            bus_read(1'b1, rv);
            chk("R8 R9 random status", rv, exp_status());
            bus_read(1'b0, rv);
            chk("R7 random data", rv, m_rxbuf);
            @(negedge clk);
            chk("R12 idle dout", dout, 8'h00);
            if (it % 4 == 3) begin
                do_reset();
                @(negedge clk);
                chk_regs("R1 reset in loop");
            end
        end

        finish_run();
    end

endmodule